// File: doc/BRIEF.md
# Serial memory status and command controller

This block is the instruction decoder and status-register keeper of a small serial nonvolatile memory reached over a mode-0 SPI link. It recognises four one-byte instructions. Two of them set or clear the write-enable latch. One returns the status byte. One writes the status byte. It keeps the 8-bit status byte, which holds a write-enable latch, a write-in-progress flag, a 2-bit block-protect field and a 2-bit watchdog-period field.

The SPI pins are sampled by the block's own clock after a parameterised synchroniser. Serial clock edges are found from the sampled level. An accepted status write starts a busy timer of `WRITE_CYCLES` clocks. The block presents the protect and watchdog fields to the rest of the chip. It also answers, from a 9-bit array address, whether a write to that address is allowed under the current protection.

The array, the array read and write instructions, and the watchdog counter are not part of this block.

Top module: `sreg_ctrl`

## Requirements
- R1: After reset the status byte reads 0x30. The layout, from bit 7 to bit 0, is 0, 0, watchdog[1], watchdog[0], protect[1], protect[0], write-enable latch, busy. After reset `prot_sel` is 0, `wdog_sel` is 3 and `spi_miso_oe` is 0.
- R2: Instructions are shifted in MSB first on rising SCK. Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect when CS rises after the complete opcode, and neither takes an address or data byte.
- R3: While `wp_n` is low the write-enable latch is cleared and held clear. A 0x06 opcode then has no effect, and so a status write is refused.
- R4: Opcode 0x01 followed by one data byte writes data bits 5:2 into the watchdog and protect fields, and only when the latch is set. Data bits 7, 6, 1 and 0 are ignored. With the latch clear, the instruction has no effect.
- R5: A status write whose CS rises before all 8 data bits have arrived is aborted, and the status byte is unchanged.
- R6: An accepted status write sets the busy flag for `WRITE_CYCLES` clocks. At the end of that time both the busy flag and the write-enable latch clear.
- R7: While busy, the opcodes 0x06, 0x04 and 0x01 are ignored.
- R8: Opcode 0x05 drives the status byte MSB first on SO, and SO changes on falling SCK. It repeats with a fresh copy of the status byte every 8 bits, and it works while busy.
- R9: `spi_miso_oe` is 0 while CS is high, during the opcode byte, and for the rest of a frame whose opcode is not one of the four.
- R10: `chk_wr_ok` is 0 for protected addresses: none for protect 0, 0x180 to 0x1FF for protect 1, 0x100 to 0x1FF for protect 2, and every address for protect 3.
- R11: `prot_sel` and `wdog_sel` always show the protect and watchdog fields of the status byte. The watchdog field encodes 0 as about 1.4 s, 1 as 600 ms, 2 as 200 ms and 3 as off.
- R12: A frame whose CS rises before 8 opcode bits have arrived has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCK |
| rst_n | input | 1 | Active-low power-on reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for serial data out |
| wp_n | input | 1 | Active-low write protect |
| chk_addr | input | ADDR_W | Array address to test for write permission |
| chk_wr_ok | output | 1 | Write allowed at `chk_addr` |
| prot_sel | output | 2 | Block-protect field |
| wdog_sel | output | 2 | Watchdog-period field |

## Verification
The bench cuts frames short, both inside the opcode and inside the data byte. A design that acted on the byte count alone would set the latch or write the status byte when it should not. It reads the status byte during a busy cycle and sends write and latch opcodes in that window. A design that blocked reads while busy would return wrong bytes, and one that honoured the opcodes would change the fields or drop the latch early. It drops `wp_n` with the latch set and then tries to set the latch and to write. A design that only cleared the latch once would accept the write. Each protect setting is probed on both sides of its boundary address, which catches an off-by-one region decode.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam logic [7:0] OP_WRITE_SR = 8'h01;
   localparam logic [7:0] OP_WR_DIS   = 8'h04;
   localparam logic [7:0] OP_READ_SR  = 8'h05;
   localparam logic [7:0] OP_WR_EN    = 8'h06;

   localparam logic [7:0] SR_RESET    = 8'h30;
   localparam int         SR_BUSY     = 0;
   localparam int         SR_LATCH    = 1;
   localparam int         SR_PROT_LO  = 2;
   localparam int         SR_WDOG_LO  = 4;

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_SET_LATCH,
      ACT_CLR_LATCH,
      ACT_WRITE
   } act_e;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_DATA,
      PH_WR,
      PH_READ,
      PH_EN,
      PH_DIS,
      PH_SKIP
   } phase_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] ff [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) ff[i] <= RST_VAL;
            end else begin
               ff[0] <= d_i;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q_o = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   input  logic [7:0] stat_i,
   output logic       so_o,
   output logic       so_oe_o,
   output act_e       act_o,
   output logic [7:0] data_o
);

   logic       sck_q, cs_q, oe_r;
   logic [2:0] bit_cnt, out_cnt;
   logic [7:0] sh_r, out_r, byte_w;
   phase_e     ph;
   logic       sck_rise, sck_fall, cs_rise, byte_end;

   assign sck_rise = ~cs_n & sck & ~sck_q;
   assign sck_fall = ~cs_n & ~sck & sck_q;
   assign cs_rise  = cs_n & ~cs_q;
   assign byte_w   = {sh_r[6:0], si};
   assign byte_end = sck_rise & (bit_cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         oe_r    <= 1'b0;
         bit_cnt <= '0;
         out_cnt <= '0;
         sh_r    <= '0;
         out_r   <= '0;
         data_o  <= '0;
         ph      <= PH_CMD;
         act_o   <= ACT_NONE;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
         act_o <= ACT_NONE;
         if (cs_n) begin
            bit_cnt <= '0;
            out_cnt <= '0;
            oe_r    <= 1'b0;
            ph      <= PH_CMD;
            if (cs_rise) begin
               case (ph)
                  PH_EN:   act_o <= ACT_SET_LATCH;
                  PH_DIS:  act_o <= ACT_CLR_LATCH;
                  PH_WR:   act_o <= ACT_WRITE;
                  default: act_o <= ACT_NONE;
               endcase
            end
         end else begin
            if (sck_rise) begin
               sh_r    <= byte_w;
               bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_end) begin
               case (ph)
                  PH_CMD: begin
                     case (byte_w)
                        OP_WR_EN:    ph <= PH_EN;
                        OP_WR_DIS:   ph <= PH_DIS;
                        OP_WRITE_SR: ph <= PH_DATA;
                        OP_READ_SR: begin
                           ph      <= PH_READ;
                           out_r   <= stat_i;
                           out_cnt <= '0;
                        end
                        default:     ph <= PH_SKIP;
                     endcase
                  end
                  PH_DATA: begin
                     data_o <= byte_w;
                     ph     <= PH_WR;
                  end
                  default: ;
               endcase
            end
            if (sck_fall && ph == PH_READ) begin
               if (!oe_r) begin
                  oe_r <= 1'b1;
               end else if (out_cnt == 3'd7) begin
                  out_r   <= stat_i;
                  out_cnt <= '0;
               end else begin
                  out_r   <= {out_r[6:0], 1'b0};
                  out_cnt <= out_cnt + 3'd1;
               end
            end
         end
      end
   end

   assign so_o    = out_r[7];
   assign so_oe_o = oe_r;

endmodule

// File: rtl/sreg_status.sv
module sreg_status
   import sreg_pkg::*;
#(
   parameter int WRITE_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wp_n,
   input  act_e       act_i,
   input  logic [7:0] data_i,
   output logic [7:0] stat_o
);

   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

   logic             latch_r, busy_r;
   logic [1:0]       prot_r, wdog_r;
   logic [CNT_W-1:0] cnt_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_r <= 1'b0;
         busy_r  <= 1'b0;
         prot_r  <= SR_RESET[SR_PROT_LO +: 2];
         wdog_r  <= SR_RESET[SR_WDOG_LO +: 2];
         cnt_r   <= '0;
      end else begin
         if (busy_r) begin
            if (cnt_r == '0) begin
               busy_r  <= 1'b0;
               latch_r <= 1'b0;
            end else begin
               cnt_r <= cnt_r - 1'b1;
            end
         end else begin
            case (act_i)
               ACT_SET_LATCH: latch_r <= 1'b1;
               ACT_CLR_LATCH: latch_r <= 1'b0;
               ACT_WRITE: begin
                  if (latch_r) begin
                     prot_r <= data_i[SR_PROT_LO +: 2];
                     wdog_r <= data_i[SR_WDOG_LO +: 2];
                     busy_r <= 1'b1;
                     cnt_r  <= CNT_LOAD;
                  end
               end
               default: ;
            endcase
         end
         if (!wp_n) latch_r <= 1'b0;
      end
   end

   assign stat_o = {2'b00, wdog_r, prot_r, latch_r, busy_r};

endmodule

// File: rtl/sreg_protect.sv
module sreg_protect #(
   parameter int ADDR_W = 9
) (
   input  logic [1:0]        bl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_ok_o
);

   logic [1:0] top2;
   logic       locked;

   assign top2 = addr_i[ADDR_W-1 -: 2];

   always_comb begin
      case (bl_i)
         2'b00:   locked = 1'b0;
         2'b01:   locked = (top2 == 2'b11);
         2'b10:   locked = top2[1];
         default: locked = 1'b1;
      endcase
   end

   assign wr_ok_o = ~locked;

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
   import sreg_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int WRITE_CYCLES = 64,
   parameter int ADDR_W       = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic              chk_wr_ok,
   output logic [1:0]        prot_sel,
   output logic [1:0]        wdog_sel
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sreg_ctrl: ADDR_W must be at least 2");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_wc
         $error("sreg_ctrl: WRITE_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sreg_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [3:0] pins_s;
   logic       cs_s, sck_s, si_s, wp_s;
   act_e       frm_act;
   logic [7:0] frm_data, stat_w;

   sreg_sync #(
      .W      (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1001)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({wp_n, spi_mosi, spi_sck, spi_cs_n}),
      .q_o  (pins_s)
   );

   assign cs_s  = pins_s[0];
   assign sck_s = pins_s[1];
   assign si_s  = pins_s[2];
   assign wp_s  = pins_s[3];

   sreg_frame u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_s),
      .sck    (sck_s),
      .si     (si_s),
      .stat_i (stat_w),
      .so_o   (spi_miso),
      .so_oe_o(spi_miso_oe),
      .act_o  (frm_act),
      .data_o (frm_data)
   );

   sreg_status #(
      .WRITE_CYCLES(WRITE_CYCLES)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .wp_n  (wp_s),
      .act_i (frm_act),
      .data_i(frm_data),
      .stat_o(stat_w)
   );

   sreg_protect #(
      .ADDR_W(ADDR_W)
   ) u_prot (
      .bl_i   (stat_w[SR_PROT_LO +: 2]),
      .addr_i (chk_addr),
      .wr_ok_o(chk_wr_ok)
   );

   assign prot_sel = stat_w[SR_PROT_LO +: 2];
   assign wdog_sel = stat_w[SR_WDOG_LO +: 2];

endmodule

// File: rtl/sreg_ctrl_chk.sv
module sreg_ctrl_chk
   import sreg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wp_s,
   input logic       cs_s,
   input logic       so_oe,
   input act_e       act,
   input logic [7:0] data,
   input logic [7:0] stat,
   input logic [1:0] bp,
   input logic       wr_ok
);

   // R3: write protect low clears the latch on the next clock
   a_r3_wp_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_s |=> !stat[SR_LATCH]);

   // R4: accepted write loads the fields and starts busy
   a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_WRITE && stat[SR_LATCH] && !stat[SR_BUSY])
      |=> (stat[SR_BUSY] && stat[5:2] == $past(data[5:2])));

   // R4: write with the latch clear leaves the fields alone
   a_r4_no_latch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_WRITE && !stat[SR_LATCH]) |=> $stable(stat[5:2]));

   // R6: busy ends together with the latch
   a_r6_busy_end_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat[SR_BUSY]) |-> !stat[SR_LATCH]);

   // R6: busy only starts from an accepted write
   a_r6_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[SR_BUSY]) |-> $past(act == ACT_WRITE));

   // R7: fields frozen while busy
   a_r7_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      stat[SR_BUSY] |=> $stable(stat[5:2]));

   // R9: no drive on SO once chip select has been high for a clock
   a_r9_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !so_oe);

   // R10: full protect blocks every address, none blocks none
   a_r10_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (bp == 2'b11) |-> !wr_ok);
   a_r10_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (bp == 2'b00) |-> wr_ok);

endmodule

bind sreg_ctrl sreg_ctrl_chk u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .wp_s (wp_s),
   .cs_s (cs_s),
   .so_oe(spi_miso_oe),
   .act  (frm_act),
   .data (frm_data),
   .stat (stat_w),
   .bp   (prot_sel),
   .wr_ok(chk_wr_ok)
);

// File: tb/sreg_ctrl_test.sv
module sreg_ctrl_test;

   localparam int HALF = 8;
   localparam int WC   = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
   logic [8:0] chk_addr = '0;
   logic       spi_miso, spi_miso_oe, chk_wr_ok;
   logic [1:0] prot_sel, wdog_sel;

   int nchk = 0, nfail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got_v;
   event       got_ev;

   always #10 clk = ~clk;

   sreg_ctrl #(.SYNC_STAGES(2), .WRITE_CYCLES(WC), .ADDR_W(9)) uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .wp_n(wp_n), .chk_addr(chk_addr), .chk_wr_ok(chk_wr_ok),
      .prot_sel(prot_sel), .wdog_sel(wdog_sel));

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic sel();
      spi_cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic desel();
      tick(HALF);
      spi_cs_n = 1'b1;
      tick(4 * HALF);
   endtask

   task automatic put_bits(logic [7:0] b, int n, bit hiz, string tag);
      for (int i = 7; i > 7 - n; i--) begin
         spi_mosi = b[i];
         tick(HALF);
         if (hiz) chk(16'(spi_miso_oe), 16'h0, tag);
         spi_sck = 1'b1;
         tick(HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic get_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         tick(HALF);
         b[i] = spi_miso_oe ? spi_miso : 1'bx;
         spi_sck = 1'b1;
         tick(HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cmd(logic [7:0] op);
      sel();
      put_bits(op, 8, 1'b0, "");
      desel();
   endtask

   task automatic wrsr(logic [7:0] d);
      sel();
      put_bits(8'h01, 8, 1'b0, "");
      put_bits(d, 8, 1'b0, "");
      desel();
   endtask

   // driver: queue expectations, then shift out the read
   task automatic rdsr(int n, logic [7:0] e, string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      sel();
      put_bits(8'h05, 8, 1'b1, "R9 SO off during opcode");
      for (int k = 0; k < n; k++) begin
         get_byte(b);
         got_v = b;
         -> got_ev;
      end
      desel();
   endtask

   task automatic probe(logic [8:0] a, logic exp, string tag);
      chk_addr = a;
      tick(1);
      chk(16'(chk_wr_ok), 16'(exp), tag);
   endtask

   // monitor: compare each returned status byte against the queue
   initial begin
      forever begin
         @(got_ev);
         if (exp_q.size() == 0) begin
            nchk++;
            nfail++;
            $display("FAIL R8 unexpected read: got %h expected none", got_v);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(16'(got_v), 16'(e), t);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R1 reset state
      chk(16'(prot_sel), 16'h0, "R1 reset protect");
      chk(16'(wdog_sel), 16'h3, "R1 reset watchdog");
      chk(16'(spi_miso_oe), 16'h0, "R1 R9 SO off after reset");
      probe(9'h1FF, 1'b1, "R10 no protect at reset");
      rdsr(1, 8'h30, "R1 R8 reset status");

      // R2 latch set and clear
      cmd(8'h06);
      rdsr(1, 8'h32, "R2 latch set");
      cmd(8'h04);
      rdsr(1, 8'h30, "R2 latch cleared");

      // R12 short opcode frame
      sel();
      put_bits(8'h06, 5, 1'b0, "");
      desel();
      rdsr(1, 8'h30, "R12 partial opcode ignored");

      // R4 write without latch
      wrsr(8'h0C);
      rdsr(1, 8'h30, "R4 write refused without latch");

      // R5 aborted data byte
      cmd(8'h06);
      sel();
      put_bits(8'h01, 8, 1'b0, "");
      put_bits(8'h3C, 5, 1'b0, "");
      desel();
      rdsr(1, 8'h32, "R5 aborted write leaves status");

      // R4 R6 R8 accepted write, read while busy
      wrsr(8'hC7);
      rdsr(2, 8'h07, "R6 R8 busy read repeats");
      cmd(8'h04);
      rdsr(1, 8'h07, "R7 latch clear ignored while busy");
      wrsr(8'h3C);
      tick(WC + 500);
      rdsr(1, 8'h04, "R6 R7 busy over, fields kept");
      chk(16'(prot_sel), 16'h1, "R11 protect field");
      chk(16'(wdog_sel), 16'h0, "R11 watchdog field");
      probe(9'h17F, 1'b1, "R10 quarter below edge");
      probe(9'h180, 1'b0, "R10 quarter at edge");

      // R10 half protect
      cmd(8'h06);
      wrsr(8'h28);
      tick(WC + 500);
      rdsr(1, 8'h28, "R4 half protect written");
      chk(16'(wdog_sel), 16'h2, "R11 watchdog 200 ms code");
      probe(9'h0FF, 1'b1, "R10 half below edge");
      probe(9'h100, 1'b0, "R10 half at edge");

      // R10 full protect
      cmd(8'h06);
      wrsr(8'h3C);
      tick(WC + 500);
      rdsr(1, 8'h3C, "R4 full protect written");
      probe(9'h000, 1'b0, "R10 full protect bottom");

      // R3 write protect
      cmd(8'h06);
      rdsr(1, 8'h3E, "R3 latch set before protect");
      wp_n = 1'b0;
      tick(10);
      rdsr(1, 8'h3C, "R3 protect clears latch");
      cmd(8'h06);
      rdsr(1, 8'h3C, "R3 latch held clear");
      wrsr(8'h00);
      tick(100);
      rdsr(1, 8'h3C, "R3 write refused under protect");
      wp_n = 1'b1;
      tick(10);

      // R9 unknown opcode
      sel();
      put_bits(8'hAA, 8, 1'b0, "");
      put_bits(8'h00, 8, 1'b1, "R9 unknown opcode keeps SO off");
      desel();

      // restore
      cmd(8'h06);
      wrsr(8'h00);
      tick(WC + 500);
      rdsr(1, 8'h00, "R4 fields cleared");
      chk(16'(prot_sel), 16'h0, "R11 protect cleared");
      probe(9'h1FF, 1'b1, "R10 top open again");

      tick(20);
      chk(16'(exp_q.size()), 16'h0, "R8 every expected read returned");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule